// File: doc/BRIEF.md
# Chained Information Block Sender

This block turns one command of any length, delivered byte by byte over a host stream, into a sequence of information blocks for a half-duplex block transport. At the start of each chain it captures the current negotiated segment size. Every segment except the last carries exactly that many bytes, and the last carries what remains. For each segment it presents the header fields to a downstream framer: the length, the more-data (chaining) bit and the one-bit send sequence number. It then streams the payload. After a segment that has a successor, it waits for the peer's receive-ready acknowledgement before it moves on.

A receive-ready acknowledgement whose number differs from the current sequence number releases the next segment. One whose number equals it is flagged as unexpected, and the same segment is presented again. An abort indication ends the chain at once and produces an abort-response strobe. The negotiated size can be changed at any time by a size-update strobe, but a chain in progress keeps the size it captured. Error detection codes and retry policy belong to the framer and the link controller.

Top module: `chain_segmenter`

## Requirements
- R1: After reset the block is idle (busy low). No strobe or valid output is high, the send sequence number is 0 and the held segment size is 32.
- R2: A cmdStart pulse while idle starts a chain of cmdLen bytes and sets busy in the following cycle. A cmdStart while busy is ignored.
- R3: Every non-final segment has length equal to the size captured at chain start. The final segment carries the remainder, from 1 up to that size. A command of length 0 yields exactly one segment of length 0, and no other empty segment is ever produced.
- R4: hdrMore is 1 on every segment that has a successor and 0 on the final segment. A length equal to an exact multiple of the size ends with a full segment that has hdrMore 0.
- R5: The first segment after reset carries hdrSeq 0. The sequence number toggles once per block that completes, meaning a chained segment accepted by a matching acknowledgement or a final segment fully sent. It carries over from chain to chain.
- R6: While waiting, an ackValid with ackSeq different from hdrSeq releases the next segment, which carries the toggled sequence number.
- R7: While waiting, an ackValid with ackSeq equal to hdrSeq raises ackErr for one cycle, in the cycle after the acknowledgement. In that same cycle the identical segment (same length, more bit, sequence number and payload) is presented again.
- R8: abortIn while busy ends the chain. In the next cycle abortRsp is high for one cycle and busy is low. The sequence number is not toggled for the unfinished segment. abortIn while idle is ignored.
- R9: A sizeUpd pulse with sizeVal in 1..254 updates the held size, and other values are ignored. The held size is captured only at cmdStart, so an update during a chain affects only later chains.
- R10: Payload bytes leave in the order the host delivered them. inReady is high only while a segment is being filled, hdrValid is high for one cycle per presentation, and outValid is high only while a payload is streamed. These three are never high together.
- R11: chainDone is high for one cycle, in the cycle after the last payload byte of the final segment is taken (or after the header of a zero-length block), and busy is low in that cycle.
- R12: ackValid while idle, filling or streaming is ignored: no ackErr and no change of sequence number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdStart | input | 1 | Start a chain (taken only when idle) |
| cmdLen | input | LEN_W | Total command length in bytes |
| sizeUpd | input | 1 | Update the held negotiated size |
| sizeVal | input | SIZE_W | New size, valid 1..MAX_SEG |
| inData | input | 8 | Host payload byte |
| inValid | input | 1 | Host byte valid |
| inReady | output | 1 | Block accepts a host byte |
| hdrValid | output | 1 | One-cycle header presentation strobe |
| hdrSeq | output | 1 | Send sequence number of the segment |
| hdrMore | output | 1 | More-data (chaining) bit |
| hdrLen | output | SIZE_W | Segment payload length |
| outData | output | 8 | Payload byte to the framer |
| outValid | output | 1 | Payload byte valid |
| outReady | input | 1 | Framer accepts the payload byte |
| ackValid | input | 1 | Receive-ready acknowledgement arrived |
| ackSeq | input | 1 | Sequence number carried by the acknowledgement |
| ackErr | output | 1 | Unexpected acknowledgement, segment re-presented |
| abortIn | input | 1 | Abort request for the chain |
| abortRsp | output | 1 | Abort response strobe |
| busy | output | 1 | A chain is in progress |
| chainDone | output | 1 | Final segment completely sent |

## Verification
Each result has a fixed latency. hdrValid rises one cycle after the last fill byte is accepted, after cmdStart for a zero-length command, or after an acknowledgement. ackErr, abortRsp and chainDone are registered and appear one cycle after the acknowledgement, the abort or the last byte transfer. A payload byte is checked in the cycle its handshake completes. The bench drives and samples only at the falling edge and steps exactly one rising edge between each stimulus and its check. Header fields, payload values and sequence numbers are predicted from a running model of remaining length, captured size and the expected sequence bit.

// File: rtl/segchain_pkg.sv
package segchain_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_HDR,
    ST_SEND,
    ST_WAIT
  } segState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic startChain;  // capture length and size
    logic fillWr;      // store one host byte
    logic sendRd;      // one payload byte consumed
    logic rewind;      // replay current segment
    logic advance;     // segment completed: drop it, toggle sequence
    logic abortClr;    // drop the chain
  } segCtl_t;

endpackage

// File: rtl/segchain_datapath.sv
module segchain_datapath
  import segchain_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int MAX_SEG  = 254,
  parameter int DEF_SIZE = 32,
  localparam int SIZE_W  = $clog2(MAX_SEG + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  segCtl_t           ctl,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic              sizeUpd,
  input  logic [SIZE_W-1:0] sizeVal,
  input  logic [7:0]        inData,
  output logic [SIZE_W-1:0] curLen,
  output logic              curMore,
  output logic              fillLast,
  output logic              sendLast,
  output logic              seqBit,
  output logic [SIZE_W-1:0] chainSize,
  output logic [7:0]        outData
);

  localparam int BUF_DEPTH = 2 ** SIZE_W;

  logic [LEN_W-1:0]  remLen;
  logic [SIZE_W-1:0] sizeReg;
  logic [SIZE_W-1:0] fillCnt;
  logic [SIZE_W-1:0] sendCnt;
  logic [7:0]        segBuf [BUF_DEPTH];
  logic              sizeOk;

  assign sizeOk   = (sizeVal != '0) && (sizeVal <= SIZE_W'(MAX_SEG));
  assign curMore  = remLen > LEN_W'(chainSize);
  assign curLen   = curMore ? chainSize : remLen[SIZE_W-1:0];
  assign fillLast = (fillCnt == curLen - SIZE_W'(1));
  assign sendLast = (sendCnt == curLen - SIZE_W'(1));
  assign outData  = segBuf[sendCnt];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sizeReg <= SIZE_W'(DEF_SIZE);
    end else if (sizeUpd && sizeOk) begin
      sizeReg <= sizeVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remLen    <= '0;
      chainSize <= SIZE_W'(DEF_SIZE);
      fillCnt   <= '0;
      sendCnt   <= '0;
      seqBit    <= 1'b0;
    end else begin
      if (ctl.startChain) begin
        remLen    <= cmdLen;
        chainSize <= sizeReg;
        fillCnt   <= '0;
        sendCnt   <= '0;
      end
      if (ctl.fillWr) fillCnt <= fillCnt + SIZE_W'(1);
      if (ctl.sendRd) sendCnt <= sendCnt + SIZE_W'(1);
      if (ctl.rewind) sendCnt <= '0;
      if (ctl.advance) begin
        remLen  <= remLen - LEN_W'(curLen);
        seqBit  <= ~seqBit;
        fillCnt <= '0;
        sendCnt <= '0;
      end
      if (ctl.abortClr) begin
        remLen  <= '0;
        fillCnt <= '0;
        sendCnt <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.fillWr) segBuf[fillCnt] <= inData;
  end

  // R9: held size always inside the legal range
  a_r9_size_range: assert property (@(posedge clk) disable iff (!rstN)
    (sizeReg != '0) && (sizeReg <= SIZE_W'(MAX_SEG)));

  // R9: captured size changes only when a chain starts
  a_r9_size_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.startChain |=> $stable(chainSize));

endmodule

// File: rtl/segchain_ctrl.sv
module segchain_ctrl
  import segchain_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdStart,
  input  logic    cmdLenZero,
  input  logic    inValid,
  input  logic    outReady,
  input  logic    ackValid,
  input  logic    ackSeq,
  input  logic    abortIn,
  input  logic    curLenZero,
  input  logic    curMore,
  input  logic    fillLast,
  input  logic    sendLast,
  input  logic    seqBit,
  output segCtl_t ctl,
  output logic    inReady,
  output logic    outValid,
  output logic    hdrValid,
  output logic    busy,
  output logic    ackErr,
  output logic    abortRsp,
  output logic    chainDone
);

  segState_e state, stateNxt;
  logic errNxt, doneNxt, abortTake;

  assign inReady   = (state == ST_FILL);
  assign outValid  = (state == ST_SEND);
  assign hdrValid  = (state == ST_HDR);
  assign busy      = (state != ST_IDLE);
  assign abortTake = abortIn && busy;

  always_comb begin
    ctl      = '0;
    stateNxt = state;
    errNxt   = 1'b0;
    doneNxt  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (cmdStart) begin
          ctl.startChain = 1'b1;
          stateNxt = cmdLenZero ? ST_HDR : ST_FILL;
        end
      end
      ST_FILL: begin
        if (inValid) begin
          ctl.fillWr = 1'b1;
          if (fillLast) stateNxt = ST_HDR;
        end
      end
      ST_HDR: begin
        if (curLenZero) begin
          ctl.advance = 1'b1;
          doneNxt  = 1'b1;
          stateNxt = ST_IDLE;
        end else begin
          stateNxt = ST_SEND;
        end
      end
      ST_SEND: begin
        if (outReady) begin
          ctl.sendRd = 1'b1;
          if (sendLast) begin
            if (curMore) begin
              stateNxt = ST_WAIT;
            end else begin
              ctl.advance = 1'b1;
              doneNxt  = 1'b1;
              stateNxt = ST_IDLE;
            end
          end
        end
      end
      ST_WAIT: begin
        if (ackValid) begin
          if (ackSeq != seqBit) begin
            ctl.advance = 1'b1;
            stateNxt = ST_FILL;
          end else begin
            ctl.rewind = 1'b1;
            errNxt   = 1'b1;
            stateNxt = ST_HDR;
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
    if (abortTake) begin
      ctl          = '0;
      ctl.abortClr = 1'b1;
      errNxt       = 1'b0;
      doneNxt      = 1'b0;
      stateNxt     = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      ackErr    <= 1'b0;
      abortRsp  <= 1'b0;
      chainDone <= 1'b0;
    end else begin
      state     <= stateNxt;
      ackErr    <= errNxt;
      abortRsp  <= abortTake;
      chainDone <= doneNxt;
    end
  end

  // R7: a repeated number flags the error and re-presents the header
  a_r7_replay: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && ackValid && ackSeq == seqBit && !abortIn)
      |=> (ackErr && hdrValid));

  // R8: abort ends the chain with a response
  a_r8_abort: assert property (@(posedge clk) disable iff (!rstN)
    (abortIn && busy) |=> (abortRsp && !busy));

  // R10: fill, header and stream phases are exclusive
  a_r10_phases: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({inReady, hdrValid, outValid}));

  // R11: completion strobe only once the block is idle
  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    chainDone |-> !busy);

  // R12: acknowledgement outside the waiting phase changes nothing
  a_r12_ack_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && state != ST_WAIT && !abortIn) |=> !ackErr);

endmodule

// File: rtl/chain_segmenter.sv
module chain_segmenter
  import segchain_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int MAX_SEG  = 254,
  parameter int DEF_SIZE = 32,
  localparam int SIZE_W  = $clog2(MAX_SEG + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic              sizeUpd,
  input  logic [SIZE_W-1:0] sizeVal,
  input  logic [7:0]        inData,
  input  logic              inValid,
  output logic              inReady,
  output logic              hdrValid,
  output logic              hdrSeq,
  output logic              hdrMore,
  output logic [SIZE_W-1:0] hdrLen,
  output logic [7:0]        outData,
  output logic              outValid,
  input  logic              outReady,
  input  logic              ackValid,
  input  logic              ackSeq,
  output logic              ackErr,
  input  logic              abortIn,
  output logic              abortRsp,
  output logic              busy,
  output logic              chainDone
);

  segCtl_t           ctl;
  logic [SIZE_W-1:0] curLen;
  logic [SIZE_W-1:0] chainSize;
  logic              curMore, fillLast, sendLast, seqBit;

  segchain_datapath #(
    .LEN_W(LEN_W), .MAX_SEG(MAX_SEG), .DEF_SIZE(DEF_SIZE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cmdLen(cmdLen),
    .sizeUpd(sizeUpd), .sizeVal(sizeVal), .inData(inData),
    .curLen(curLen), .curMore(curMore), .fillLast(fillLast),
    .sendLast(sendLast), .seqBit(seqBit), .chainSize(chainSize),
    .outData(outData)
  );

  segchain_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart),
    .cmdLenZero(cmdLen == '0), .inValid(inValid), .outReady(outReady),
    .ackValid(ackValid), .ackSeq(ackSeq), .abortIn(abortIn),
    .curLenZero(curLen == '0), .curMore(curMore), .fillLast(fillLast),
    .sendLast(sendLast), .seqBit(seqBit), .ctl(ctl),
    .inReady(inReady), .outValid(outValid), .hdrValid(hdrValid),
    .busy(busy), .ackErr(ackErr), .abortRsp(abortRsp),
    .chainDone(chainDone)
  );

  assign hdrSeq  = seqBit;
  assign hdrMore = curMore;
  assign hdrLen  = curLen;

  // R3: a chained segment is always full size
  a_r3_full_segment: assert property (@(posedge clk) disable iff (!rstN)
    (hdrValid && hdrMore) |-> (hdrLen == chainSize));

  // R4: a short or empty segment never claims a successor
  a_r4_short_is_last: assert property (@(posedge clk) disable iff (!rstN)
    (hdrValid && hdrLen < chainSize) |-> !hdrMore);

  // R3: no segment exceeds the captured size
  a_r3_len_bound: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid |-> (hdrLen <= chainSize));

endmodule

// File: tb/chain_segmenter_test.sv
module chain_segmenter_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cmdStart = 0, sizeUpd = 0, inValid = 0, outReady = 0;
  logic        ackValid = 0, ackSeq = 0, abortIn = 0;
  logic [15:0] cmdLen = '0;
  logic [7:0]  sizeVal = '0, inData = '0;
  logic        inReady, hdrValid, hdrSeq, hdrMore, outValid;
  logic        ackErr, abortRsp, busy, chainDone;
  logic [7:0]  hdrLen, outData;

  int total = 0, bad = 0;
  int expSeq = 0, sizeNow = 32, chainId = 0;

  always #4 clk = ~clk;

  chain_segmenter uut (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdLen(cmdLen),
    .sizeUpd(sizeUpd), .sizeVal(sizeVal), .inData(inData),
    .inValid(inValid), .inReady(inReady), .hdrValid(hdrValid),
    .hdrSeq(hdrSeq), .hdrMore(hdrMore), .hdrLen(hdrLen),
    .outData(outData), .outValid(outValid), .outReady(outReady),
    .ackValid(ackValid), .ackSeq(ackSeq), .ackErr(ackErr),
    .abortIn(abortIn), .abortRsp(abortRsp), .busy(busy),
    .chainDone(chainDone)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int c, input int i);
    return 8'((c * 37 + i * 5 + 1) & 255);
  endfunction

  function automatic int segLen(input int rem, input int sz);
    return (rem > sz) ? sz : rem;
  endfunction

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setSize(input int v);
    sizeUpd = 1; sizeVal = 8'(v);
    cyc();
    sizeUpd = 0;
    if (v >= 1 && v <= 254) sizeNow = v;
  endtask

  // abortSeg: segment index after which to abort in the waiting phase (-1 none)
  task automatic runChain(input int len, input int errPct, input int abortSeg,
                          input bit forceWrong, input bit midSize);
    int rem = len, base = 0, hostIdx = 0, cs = sizeNow, seg = 0, attempt = 0;
    bit done = 0;
    cmdStart = 1; cmdLen = 16'(len);
    cyc();
    cmdStart = 0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    while (!done) begin
      int el = segLen(rem, cs);
      bit em = rem > cs;
      int guard = 0;
      while (!hdrValid && guard < 4000) begin
        inValid = ($urandom % 4) != 0;
        inData  = pat(chainId, hostIdx);
        if (inValid && inReady) hostIdx++;
        cyc();
        guard++;
      end
      inValid = 0;
      chk(hdrValid == 1'b1, "R10 header presented", hdrValid, 1);
      chk(int'(hdrLen) == el, "R3 segment length", hdrLen, el);
      chk(hdrMore == em, "R4 more bit", hdrMore, em);
      chk(hdrSeq == expSeq[0], "R5 sequence number", hdrSeq, expSeq);
      chk(!inReady && !outValid, "R10 exclusive phases", {inReady, outValid}, 0);
      if (guard >= 4000) begin
        done = 1;
      end else begin
        cyc();
        if (el == 0) begin
          chk(chainDone == 1'b1, "R11 done after empty block", chainDone, 1);
          chk(busy == 1'b0, "R11 idle after empty block", busy, 0);
          expSeq ^= 1;
          done = 1;
        end else begin
          int n = 0;
          int g2 = 0;
          cmdStart = 1; cmdLen = 16'd3;   // must be ignored while busy (R2)
          while (n < el && g2 < 4000) begin
            outReady = ($urandom % 3) != 0;
            if (outValid && outReady) begin
              chk(outData == pat(chainId, base + n), "R10 payload order",
                  outData, pat(chainId, base + n));
              n++;
            end
            cyc();
            cmdStart = 0;
            g2++;
          end
          outReady = 0;
          cmdStart = 0;
          if (!em) begin
            chk(chainDone == 1'b1, "R11 done after final byte", chainDone, 1);
            chk(busy == 1'b0, "R11 idle after final byte", busy, 0);
            expSeq ^= 1;
            done = 1;
          end else begin
            chk(busy && !chainDone, "R6 waiting for acknowledgement", {busy, chainDone}, 2);
            repeat ($urandom % 3) cyc();
            if (seg == abortSeg) begin
              abortIn = 1;
              cyc();
              abortIn = 0;
              chk(abortRsp == 1'b1, "R8 abort response", abortRsp, 1);
              chk(busy == 1'b0, "R8 idle after abort", busy, 0);
              done = 1;
            end else begin
              bit wrong = (forceWrong && attempt == 0) || (($urandom % 100) < errPct);
              if (midSize && seg == 0) setSize(7);
              ackValid = 1;
              ackSeq   = wrong ? expSeq[0] : ~expSeq[0];
              cyc();
              ackValid = 0;
              chk(ackErr == wrong, wrong ? "R7 unexpected ack flagged" : "R6 matching ack accepted",
                  ackErr, wrong);
              if (wrong) begin
                attempt++;
              end else begin
                rem -= el; base += el; expSeq ^= 1; seg++; attempt = 0;
              end
            end
          end
        end
      end
    end
    cyc();
    chk(chainDone == 1'b0 && abortRsp == 1'b0, "R11 strobes last one cycle",
        {chainDone, abortRsp}, 0);
    chainId++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired (R10 progress) actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state
    chk(!busy && !inReady && !outValid && !hdrValid, "R1 idle after reset",
        {busy, inReady, outValid, hdrValid}, 0);
    chk(!ackErr && !abortRsp && !chainDone, "R1 strobes low after reset",
        {ackErr, abortRsp, chainDone}, 0);

    runChain(70, 0, -1, 0, 0);    // R1 default size 32, R5 first seq 0
    runChain(0, 0, -1, 0, 0);     // R3 zero-length command
    runChain(64, 0, -1, 0, 0);    // R4 exact multiple

    // R12: ack while idle ignored
    ackValid = 1; ackSeq = ~expSeq[0];
    cyc();
    ackValid = 0;
    chk(ackErr == 1'b0 && busy == 1'b0, "R12 ack ignored when idle", {ackErr, busy}, 0);

    // R9: illegal sizes ignored, legal size taken
    setSize(0);
    setSize(255);
    runChain(40, 0, -1, 0, 0);
    setSize(1);
    runChain(3, 0, -1, 0, 0);
    setSize(32);

    runChain(50, 0, -1, 1, 0);    // R7 forced wrong ack per segment
    runChain(100, 0, 1, 0, 0);    // R8 abort while waiting
    runChain(10, 0, -1, 0, 0);    // R5 seq after abort not toggled

    // R8: abort during fill
    cmdStart = 1; cmdLen = 16'd10;
    cyc();
    cmdStart = 0;
    for (int i = 0; i < 3; i++) begin
      inValid = 1; inData = pat(chainId, i);
      cyc();
    end
    inValid = 0;
    abortIn = 1;
    cyc();
    abortIn = 0;
    chk(abortRsp && !busy && !inReady, "R8 abort during fill",
        {abortRsp, busy, inReady}, 4);
    chainId++;
    abortIn = 1;
    cyc();
    abortIn = 0;
    chk(abortRsp == 1'b0, "R8 abort ignored when idle", abortRsp, 0);

    runChain(60, 0, -1, 0, 1);    // R9 mid-chain update kept for next chain
    runChain(20, 0, -1, 0, 0);    // size 7 now in force

    for (int k = 0; k < 25; k++) begin
      int sz = 1 + ($urandom % 254);
      int ln = (($urandom % 6) == 0) ? 0 : int'($urandom % 260);
      setSize(sz);
      runChain(ln, 25, (($urandom % 8) == 0) ? 0 : -1, 0, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule